// File: doc/BRIEF.md
# Data, peripheral and stack address unit

This block produces the addresses for three address spaces that a processor core reaches through one external memory port: a byte-addressed data space, a separate peripheral space and an upward-growing stack. It holds three 32-bit pointers: a data pointer, a peripheral pointer and a stack pointer. Each cycle it may take one decoded access command. It drives the port's address, space code, size code and read or write strobe in that same cycle, combinationally. It then moves the pointer the access used at the next rising clock edge.

Data and peripheral accesses come in byte, short and long sizes. A post-increment form advances the pointer used by the size of the transfer. The stack moves in long words. A push writes at the stack pointer and then moves it up. A pull first moves it down and reads at the lowered address. Two further stack forms store or load at the stack pointer without moving it. Any pointer can also be overwritten from a shared 32-bit load port. When that load meets an update of the same pointer in the same cycle, the load wins.

Top module: `addr_unit`

## Requirements
- R1: While rst_n is low, all three pointers are cleared to zero. With no command, mem_rd, mem_wr, mem_addr, mem_space and mem_size are all zero.
- R2: A valid command with cmd_space=0 (data) drives mem_addr equal to the data pointer and mem_space=0. It echoes cmd_size on mem_size (0 byte, 1 short, 2 long). It asserts mem_rd when cmd_write=0 and mem_wr when cmd_write=1, in the same cycle.
- R3: A valid command with cmd_space=1 (peripheral) drives mem_addr equal to the peripheral pointer and mem_space=1, with size and strobes as in R2.
- R4: With cmd_postinc=1, a data or peripheral access adds 1, 2 or 4 to the pointer it used, for size code 0, 1 or 2, at the next clock edge. The other pointers do not change.
- R5: With cmd_postinc=0, a data or peripheral access leaves every pointer unchanged.
- R6: A stack command (cmd_space=2) with cmd_stack_op=0 (push) drives a long write (mem_size=2, mem_space=2) at the current stack pointer. The stack pointer then rises by 4.
- R7: A stack command with cmd_stack_op=1 (pull) drives a long read at the stack pointer minus 4 in the same cycle. The stack pointer then becomes that lowered value.
- R8: A stack command with cmd_stack_op=2 drives a long write at the stack pointer, and cmd_stack_op=3 a long read at it. Neither changes the stack pointer.
- R9: ld_en bit 0, 1 or 2 loads ld_value into the data, peripheral or stack pointer, visible after the next clock edge. A load takes priority over a post-increment, push or pull that updates the same pointer in that cycle.
- R10: mem_rd and mem_wr are never high together. With cmd_valid=0, or with cmd_space=3, no strobe is driven and no pointer moves.
- R11: Pointer arithmetic wraps modulo 2^32. Incrementing 0xFFFFFFFF by 1 gives 0, and a pull at stack pointer 0 reads at 0xFFFFFFFC and leaves that value in the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | An access command is present this cycle |
| cmd_space | input | 2 | 0 data, 1 peripheral, 2 stack, 3 no access |
| cmd_write | input | 1 | 1 store, 0 load (data and peripheral spaces) |
| cmd_size | input | 2 | 0 byte, 1 short, 2 long (data and peripheral spaces) |
| cmd_postinc | input | 1 | Advance the used pointer after the access |
| cmd_stack_op | input | 2 | 0 push, 1 pull, 2 store at pointer, 3 load at pointer |
| ld_en | input | 3 | Pointer load enables: bit 0 data, bit 1 peripheral, bit 2 stack |
| ld_value | input | 32 | Value written by a pointer load |
| mem_addr | output | 32 | Access address |
| mem_space | output | 2 | Space code of the access |
| mem_size | output | 2 | Size code of the access |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| ptr_data | output | 32 | Current data pointer |
| ptr_periph | output | 32 | Current peripheral pointer |
| ptr_stack | output | 32 | Current stack pointer |

## Verification
The two functions that can meet in one cycle are a pointer load and an access that updates the same pointer. The bench provokes this by raising ld_en for the data pointer together with a long post-increment data access, and by loading the stack pointer in the cycle of a push. It judges the pair by checking two things. The access address must still come from the old pointer value. After the edge, the pointer must hold the loaded value and not the incremented one.

// File: rtl/addr_unit_pkg.sv
package addr_unit_pkg;

    localparam int ADDR_W = 32;
    localparam int NPTR   = 3;
    localparam int STEP_W = 3;

    typedef enum logic [1:0] {
        SPC_DATA   = 2'd0,
        SPC_PERIPH = 2'd1,
        SPC_STACK  = 2'd2,
        SPC_NONE   = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_SHORT = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_RSVD  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        STK_PUSH  = 2'd0,
        STK_PULL  = 2'd1,
        STK_STORE = 2'd2,
        STK_LOAD  = 2'd3
    } stack_op_e;

    localparam int PTR_DATA   = 0;
    localparam int PTR_PERIPH = 1;
    localparam int PTR_STACK  = 2;

    // Decoded access: which pointer, how it moves, what the port sees.
    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [1:0]        space;
        logic [1:0]        size;
        logic [NPTR-1:0]   sel;
        logic              move;
        logic              up;
        logic              pre;
        logic [STEP_W-1:0] step;
    } access_t;

    function automatic logic [STEP_W-1:0] step_of(input logic [1:0] sz);
        case (sz)
            SZ_BYTE:  step_of = STEP_W'(1);
            SZ_SHORT: step_of = STEP_W'(2);
            default:  step_of = STEP_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/au_cmd_decode.sv
module au_cmd_decode
    import addr_unit_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_space,
    input  logic       cmd_write,
    input  logic [1:0] cmd_size,
    input  logic       cmd_postinc,
    input  logic [1:0] cmd_stack_op,
    output access_t    acc
);

    always_comb begin
        acc = '0;
        if (cmd_valid) begin
            case (space_e'(cmd_space))
                SPC_DATA, SPC_PERIPH: begin
                    acc.space = cmd_space;
                    acc.size  = cmd_size;
                    acc.sel   = (space_e'(cmd_space) == SPC_DATA)
                              ? NPTR'(1 << PTR_DATA) : NPTR'(1 << PTR_PERIPH);
                    acc.rd    = !cmd_write;
                    acc.wr    = cmd_write;
                    acc.move  = cmd_postinc;
                    acc.up    = 1'b1;
                    acc.step  = step_of(cmd_size);
                end
                SPC_STACK: begin
                    acc.space = cmd_space;
                    acc.size  = SZ_LONG;
                    acc.sel   = NPTR'(1 << PTR_STACK);
                    acc.step  = step_of(SZ_LONG);
                    case (stack_op_e'(cmd_stack_op))
                        STK_PUSH: begin
                            acc.wr   = 1'b1;
                            acc.move = 1'b1;
                            acc.up   = 1'b1;
                        end
                        STK_PULL: begin
                            acc.rd   = 1'b1;
                            acc.move = 1'b1;
                            acc.pre  = 1'b1;
                        end
                        STK_STORE: acc.wr = 1'b1;
                        default:   acc.rd = 1'b1;
                    endcase
                end
                default: acc = '0;
            endcase
        end
    end

    // R10: one pointer at most, one strobe at most
    always_comb begin
        a_r10_one_pointer: assert ($onehot0(acc.sel));
        a_r10_one_strobe:  assert (!(acc.rd && acc.wr));
    end

endmodule

// File: rtl/au_pointer.sv
module au_pointer
    import addr_unit_pkg::*;
#(
    parameter int W  = ADDR_W,
    parameter int SW = STEP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [W-1:0]  load_val,
    input  logic          step_en,
    input  logic          step_up,
    input  logic [SW-1:0] step_amt,
    output logic [W-1:0]  ptr
);

    typedef struct packed {
        logic [W-1:0] value;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.value = load_val;
        end else if (step_en) begin
            st_d.value = step_up ? st_q.value + W'(step_amt)
                                 : st_q.value - W'(step_amt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.value;

    // R9: a load wins over any concurrent step
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> ptr == $past(load_val));

    // R4: upward step adds the amount, wrapping
    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && !load_en) |=> ptr == W'($past(ptr) + W'($past(step_amt))));

    // R7: downward step subtracts the amount
    a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && !load_en) |=> ptr == W'($past(ptr) - W'($past(step_amt))));

    // R5: nothing requested, nothing moves
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> $stable(ptr));

endmodule

// File: rtl/addr_unit.sv
module addr_unit
    import addr_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_space,
    input  logic              cmd_write,
    input  logic [1:0]        cmd_size,
    input  logic              cmd_postinc,
    input  logic [1:0]        cmd_stack_op,
    input  logic [NPTR-1:0]   ld_en,
    input  logic [ADDR_W-1:0] ld_value,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_space,
    output logic [1:0]        mem_size,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] ptr_data,
    output logic [ADDR_W-1:0] ptr_periph,
    output logic [ADDR_W-1:0] ptr_stack
);

    access_t           acc;
    logic [ADDR_W-1:0] ptr_q [NPTR];
    logic [ADDR_W-1:0] base;

    au_cmd_decode u_dec (
        .cmd_valid    (cmd_valid),
        .cmd_space    (cmd_space),
        .cmd_write    (cmd_write),
        .cmd_size     (cmd_size),
        .cmd_postinc  (cmd_postinc),
        .cmd_stack_op (cmd_stack_op),
        .acc          (acc)
    );

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        au_pointer #(.W(ADDR_W), .SW(STEP_W)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (ld_en[i]),
            .load_val (ld_value),
            .step_en  (acc.move && acc.sel[i]),
            .step_up  (acc.up),
            .step_amt (acc.step),
            .ptr      (ptr_q[i])
        );
    end

    always_comb begin
        base = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (acc.sel[i]) base = ptr_q[i];
        end
    end

    assign mem_addr   = acc.pre ? base - ADDR_W'(acc.step) : base;
    assign mem_space  = acc.space;
    assign mem_size   = acc.size;
    assign mem_rd     = acc.rd;
    assign mem_wr     = acc.wr;
    assign ptr_data   = ptr_q[PTR_DATA];
    assign ptr_periph = ptr_q[PTR_PERIPH];
    assign ptr_stack  = ptr_q[PTR_STACK];

    // R6: a push writes a long at the present stack pointer
    a_r6_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_space == SPC_STACK && cmd_stack_op == STK_PUSH)
        |-> (mem_wr && mem_addr == ptr_stack && mem_size == SZ_LONG));

    // R7: a pull reads where the stack pointer lands afterwards
    a_r7_pull_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_space == SPC_STACK && cmd_stack_op == STK_PULL && !ld_en[PTR_STACK])
        |=> ptr_stack == $past(mem_addr));

    // R2: a data access is addressed by the data pointer
    a_r2_data_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_space == SPC_DATA) |-> mem_addr == ptr_data);

    // R10: no command, no strobe
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> !(mem_rd || mem_wr));

endmodule

// File: tb/tb_addr_unit.sv
`timescale 1ns/1ps
module tb_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_space = 2'd0;
    logic        cmd_write = 1'b0;
    logic [1:0]  cmd_size = 2'd0;
    logic        cmd_postinc = 1'b0;
    logic [1:0]  cmd_stack_op = 2'd0;
    logic [2:0]  ld_en = 3'b000;
    logic [31:0] ld_value = '0;
    logic [31:0] mem_addr;
    logic [1:0]  mem_space;
    logic [1:0]  mem_size;
    logic        mem_rd;
    logic        mem_wr;
    logic [31:0] ptr_data;
    logic [31:0] ptr_periph;
    logic [31:0] ptr_stack;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    addr_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_space(cmd_space),
        .cmd_write(cmd_write), .cmd_size(cmd_size), .cmd_postinc(cmd_postinc),
        .cmd_stack_op(cmd_stack_op), .ld_en(ld_en), .ld_value(ld_value),
        .mem_addr(mem_addr), .mem_space(mem_space), .mem_size(mem_size),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ptr_data(ptr_data),
        .ptr_periph(ptr_periph), .ptr_stack(ptr_stack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [1:0] spc, input logic wr,
                         input logic [1:0] sz, input logic pi, input logic [1:0] op);
        @(negedge clk);
        cmd_valid = v; cmd_space = spc; cmd_write = wr;
        cmd_size = sz; cmd_postinc = pi; cmd_stack_op = op;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cmd_valid = 1'b0; ld_en = 3'b000;
    endtask

    task automatic load_ptr(input int idx, input logic [31:0] val);
        @(negedge clk);
        ld_en = 3'b000; ld_en[idx] = 1'b1; ld_value = val;
        tick();
    endtask

    task automatic port(input string tag, input logic [31:0] a, input logic [1:0] spc,
                        input logic [1:0] sz, input logic rd, input logic wr);
        chk({tag, " addr"}, mem_addr, a);
        chk({tag, " space"}, {30'd0, mem_space}, {30'd0, spc});
        chk({tag, " size"}, {30'd0, mem_size}, {30'd0, sz});
        chk({tag, " rd"}, {31'd0, mem_rd}, {31'd0, rd});
        chk({tag, " wr"}, {31'd0, mem_wr}, {31'd0, wr});
    endtask

    task automatic t_reset();
        #1;
        chk("R1 data ptr", ptr_data, 32'h0);
        chk("R1 periph ptr", ptr_periph, 32'h0);
        chk("R1 stack ptr", ptr_stack, 32'h0);
        port("R1 idle", 32'h0, 2'd0, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_load();
        load_ptr(0, 32'h0000_0100);
        load_ptr(1, 32'h0000_2000);
        load_ptr(2, 32'h0000_8000);
        chk("R9 load data", ptr_data, 32'h100);
        chk("R9 load periph", ptr_periph, 32'h2000);
        chk("R9 load stack", ptr_stack, 32'h8000);
    endtask

    task automatic t_data();
        apply(1, 2'd0, 0, 2'd0, 0, 2'd0);
        port("R2 byte load", 32'h100, 2'd0, 2'd0, 1'b1, 1'b0);
        tick();
        chk("R5 no postinc", ptr_data, 32'h100);
        apply(1, 2'd0, 1, 2'd1, 1, 2'd0);
        port("R2 short store", 32'h100, 2'd0, 2'd1, 1'b0, 1'b1);
        tick();
        chk("R4 short step", ptr_data, 32'h102);
        apply(1, 2'd0, 0, 2'd2, 1, 2'd0);
        port("R2 long load", 32'h102, 2'd0, 2'd2, 1'b1, 1'b0);
        tick();
        chk("R4 long step", ptr_data, 32'h106);
        apply(1, 2'd0, 0, 2'd0, 1, 2'd0);
        tick();
        chk("R4 byte step", ptr_data, 32'h107);
        chk("R4 periph untouched", ptr_periph, 32'h2000);
    endtask

    task automatic t_periph();
        apply(1, 2'd1, 1, 2'd2, 1, 2'd0);
        port("R3 long store", 32'h2000, 2'd1, 2'd2, 1'b0, 1'b1);
        tick();
        chk("R4 periph step", ptr_periph, 32'h2004);
        chk("R4 data untouched", ptr_data, 32'h107);
        apply(1, 2'd1, 0, 2'd0, 0, 2'd0);
        port("R3 byte load", 32'h2004, 2'd1, 2'd0, 1'b1, 1'b0);
        tick();
        chk("R5 periph held", ptr_periph, 32'h2004);
    endtask

    task automatic t_stack();
        apply(1, 2'd2, 0, 2'd0, 0, 2'd0);
        port("R6 push", 32'h8000, 2'd2, 2'd2, 1'b0, 1'b1);
        tick();
        chk("R6 push step", ptr_stack, 32'h8004);
        apply(1, 2'd2, 0, 2'd0, 0, 2'd0);
        tick();
        chk("R6 second push", ptr_stack, 32'h8008);
        apply(1, 2'd2, 0, 2'd0, 0, 2'd1);
        port("R7 pull", 32'h8004, 2'd2, 2'd2, 1'b1, 1'b0);
        tick();
        chk("R7 pull step", ptr_stack, 32'h8004);
        apply(1, 2'd2, 0, 2'd0, 1, 2'd2);
        port("R8 store at sp", 32'h8004, 2'd2, 2'd2, 1'b0, 1'b1);
        tick();
        chk("R8 store keeps sp", ptr_stack, 32'h8004);
        apply(1, 2'd2, 0, 2'd0, 0, 2'd3);
        port("R8 load at sp", 32'h8004, 2'd2, 2'd2, 1'b1, 1'b0);
        tick();
        chk("R8 load keeps sp", ptr_stack, 32'h8004);
    endtask

    task automatic t_priority();
        apply(1, 2'd0, 0, 2'd2, 1, 2'd0);
        ld_en = 3'b001; ld_value = 32'h0000_0500;
        #0.1;
        chk("R9 addr uses old data ptr", mem_addr, 32'h107);
        tick();
        chk("R9 load beats postinc", ptr_data, 32'h500);
        apply(1, 2'd2, 0, 2'd0, 0, 2'd0);
        ld_en = 3'b100; ld_value = 32'h0000_9000;
        #0.1;
        chk("R9 push addr old sp", mem_addr, 32'h8004);
        tick();
        chk("R9 load beats push", ptr_stack, 32'h9000);
    endtask

    task automatic t_idle();
        apply(0, 2'd0, 1, 2'd2, 1, 2'd0);
        chk("R10 invalid no wr", {31'd0, mem_wr}, 32'd0);
        chk("R10 invalid no rd", {31'd0, mem_rd}, 32'd0);
        tick();
        chk("R10 invalid data held", ptr_data, 32'h500);
        apply(1, 2'd3, 0, 2'd2, 1, 2'd0);
        chk("R10 space3 no strobe", {30'd0, mem_rd, mem_wr}, 32'd0);
        tick();
        chk("R10 space3 data held", ptr_data, 32'h500);
        chk("R10 space3 periph held", ptr_periph, 32'h2004);
        chk("R10 space3 stack held", ptr_stack, 32'h9000);
    endtask

    task automatic t_wrap();
        load_ptr(0, 32'hFFFF_FFFF);
        apply(1, 2'd0, 1, 2'd0, 1, 2'd0);
        tick();
        chk("R11 data wrap", ptr_data, 32'h0);
        load_ptr(2, 32'h0);
        apply(1, 2'd2, 0, 2'd0, 0, 2'd1);
        chk("R11 pull addr wrap", mem_addr, 32'hFFFF_FFFC);
        tick();
        chk("R11 stack wrap", ptr_stack, 32'hFFFF_FFFC);
    endtask

    initial begin
        #2000000;
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_load();
        t_data();
        t_periph();
        t_stack();
        t_priority();
        t_idle();
        t_wrap();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule